// File: doc/BRIEF.md
# UART Register and Command Front End

This block is the register-facing half of a byte-wide serial channel. A host talks to it over a simple single-cycle bus inside a 64-byte window. It holds two mode bytes reached through a self-advancing pointer, two baud bytes, and an interrupt mask. It assembles a status byte and an interrupt-status byte from its own transmit state and from the receive buffer. A single packed command byte carries three subcommands: a miscellaneous action, a transmitter control and a receiver control. The block applies them in that order.

Transmit bytes leave on a valid/ready byte stream. A byte stays in the holding register, and the buffer counts as not empty, until the sink accepts it. `tx_valid` is high exactly when the transmitter is enabled and a byte is held. While `tx_valid` is high and `tx_ready` is low, `tx_data` does not change. Disabling or resetting the transmitter withdraws `tx_valid`: disabling keeps the byte held, and a transmitter reset discards it. The receive buffer is a separate block. This block pops it when the host reads the data offset, clears it on a receiver reset, and reads its level and error flags. A level interrupt is raised while any unmasked interrupt-status bit is set.

Top module: `uart_regfront`

## Requirements
- R1: After reset the status byte reads 0x08, interrupt status and mask are 0, `irq` is low, both mode bytes read 0, `tx_valid` and `rx_en` are low.
- R2: Offset 0x00 reads and writes the mode byte selected by a pointer that starts at mode byte 1. Every write there moves the pointer to mode byte 2, and only a misc action 1 command (or reset) moves it back.
- R3: Status byte (offset 0x04) bits: 0 receive data present, 1 receive buffer full, 2 transmitter enabled, 3 transmit holding register empty, 4 overrun, 5 parity error, 6 framing error, 7 break received. Bits 4 to 7 come from `rxb_err[0]` to `rxb_err[3]`.
- R4: A write to offset 0x0C loads the holding register and clears the empty bit. While the transmitter is disabled the byte is kept and `tx_valid` stays low. Enabling the transmitter later presents the byte.
- R5: The byte is consumed only on a cycle where `tx_valid` and `tx_ready` are both high, and the empty bit is set on the next cycle. A new buffer write in that same cycle takes the register over, and that byte is sent next.
- R6: Command bits 3:2 control the transmitter: 1 enables it, 2 disables it, 0 and 3 leave it unchanged.
- R7: Command bits 1:0 control the receiver through `rx_en` with the same coding. Misc action 2 (bits 6:4) disables the receiver and pulses `rxb_clear` in the command write cycle.
- R8: In one command byte the misc action is applied first, then the transmitter field, then the receiver field. For example, 0x35 leaves both the transmitter and the receiver enabled.
- R9: Misc action 3 disables the transmitter, sets the empty bit and discards the held byte.
- R10: Interrupt status (offset 0x14 read) bit 0 equals status bit 2. Bit 1 equals status bit 1 when mode byte 1 bit 6 is set, and status bit 0 otherwise. Writing 0x14 sets the mask, and `irq` is high while status AND mask is nonzero.
- R11: A `brk_evt` pulse sets interrupt-status bit 2. Misc action 5 clears it. An event in the same cycle as the clear leaves the bit set.
- R12: Reading offset 0x0C while `rxb_nonempty` is high returns `rxb_data` and pulses `rxb_pop` in the same cycle. While the buffer is empty the read returns 0 and does not pop.
- R13: Writes to the status offset and to unmapped offsets change nothing. Unmapped offsets and the command offset read 0. Misc action 4 pulses `rxb_err_clr`, and actions 6 and 7 have no effect.
- R14: Offsets 0x18 and 0x1C hold two baud bytes, each written and read back at its own offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for pop side effect) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Sink accepts byte |
| rx_en | output | 1 | Receiver enabled |
| rxb_data | input | 8 | Head byte of receive buffer |
| rxb_nonempty | input | 1 | Receive buffer holds data |
| rxb_full | input | 1 | Receive buffer full |
| rxb_err | input | 4 | Overrun, parity, framing, break flags |
| rxb_pop | output | 1 | Remove head byte |
| rxb_clear | output | 1 | Empty the receive buffer |
| rxb_err_clr | output | 1 | Clear receive error flags |
| brk_evt | input | 1 | Break detected pulse |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, the sink accepts the held byte in the same cycle as the host writes a new one. The bench stalls `tx_ready`, loads a byte, then raises `tx_ready` in the cycle of a second buffer write. The accepted-byte log must show the first byte and then the second, with neither lost nor repeated. In the second pair, a break event arrives in the same cycle as the command that clears the delta-break bit, and the bit must read back as set.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  localparam int WIN_AW = 6;
  localparam int BYTE_W = 8;
  localparam int ERR_W  = 4;
  localparam int NUM_MODE = 2;
  localparam int NUM_BAUD = 2;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WIN_AW-1:0] ofs_t;

  localparam ofs_t OFS_MODE  = 6'h00;
  localparam ofs_t OFS_STAT  = 6'h04;
  localparam ofs_t OFS_CMD   = 6'h08;
  localparam ofs_t OFS_DATA  = 6'h0C;
  localparam ofs_t OFS_INT   = 6'h14;
  localparam ofs_t OFS_BAUD0 = 6'h18;
  localparam ofs_t OFS_BAUD1 = 6'h1C;

  // status byte positions
  localparam int ST_RXRDY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMP = 3;
  localparam int ST_ERR0  = 4;

  // interrupt status positions
  localparam int IS_TX   = 0;
  localparam int IS_RX   = 1;
  localparam int IS_DBRK = 2;

  // mode byte 1 bit choosing the receive interrupt source
  localparam int MODE_RXSRC = 6;

  typedef enum logic [2:0] {
    MISC_NOP, MISC_PTR_RST, MISC_RX_RST, MISC_TX_RST,
    MISC_ERR_RST, MISC_DBRK_CLR, MISC_BRK_ON, MISC_BRK_OFF
  } misc_op_e;

  typedef enum logic [1:0] {CTL_NOP, CTL_ON, CTL_OFF, CTL_RSV} ctl_e;
endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_regfront_pkg::*;
(
  input  logic       cmd_we,
  input  logic [6:0] cmd,
  input  logic       tx_en_q,
  input  logic       rx_en_q,
  output logic       tx_en_d,
  output logic       rx_en_d,
  output logic       ptr_rst,
  output logic       rx_rst,
  output logic       tx_rst,
  output logic       err_clr,
  output logic       dbrk_clr
);
  misc_op_e misc;
  ctl_e     txc;
  ctl_e     rxc;

  assign misc = misc_op_e'(cmd[6:4]);
  assign txc  = ctl_e'(cmd[3:2]);
  assign rxc  = ctl_e'(cmd[1:0]);

  always_comb begin
    tx_en_d  = tx_en_q;
    rx_en_d  = rx_en_q;
    ptr_rst  = 1'b0;
    rx_rst   = 1'b0;
    tx_rst   = 1'b0;
    err_clr  = 1'b0;
    dbrk_clr = 1'b0;
    if (cmd_we) begin
      // stage 1: miscellaneous action
      unique case (misc)
        MISC_PTR_RST:  ptr_rst = 1'b1;
        MISC_RX_RST: begin
          rx_rst  = 1'b1;
          rx_en_d = 1'b0;
        end
        MISC_TX_RST: begin
          tx_rst  = 1'b1;
          tx_en_d = 1'b0;
        end
        MISC_ERR_RST:  err_clr  = 1'b1;
        MISC_DBRK_CLR: dbrk_clr = 1'b1;
        default: ;
      endcase
      // stage 2: transmitter field
      unique case (txc)
        CTL_ON:  tx_en_d = 1'b1;
        CTL_OFF: tx_en_d = 1'b0;
        default: ;
      endcase
      // stage 3: receiver field
      unique case (rxc)
        CTL_ON:  rx_en_d = 1'b1;
        CTL_OFF: rx_en_d = 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_regfront_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t load_data,
  input  logic  flush,
  input  logic  tx_en,
  output byte_t tx_data,
  output logic  tx_valid,
  input  logic  tx_ready,
  output logic  empty
);
  byte_t hold_q;
  logic  empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
    end else if (flush) begin
      empty_q <= 1'b1;
    end else if (load) begin
      hold_q  <= load_data;
      empty_q <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      empty_q <= 1'b1;
    end
  end

  assign tx_data  = hold_q;
  assign tx_valid = tx_en && !empty_q;
  assign empty    = empty_q;

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !load && !flush) |=> (!empty && $stable(tx_data)));

  // R5
  accept_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !load && !flush) |=> empty);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !tx_valid));
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_regfront_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tx_rdy,
  input  logic  rx_rdy,
  input  logic  rx_full,
  input  logic  rx_src_full,
  input  logic  brk_evt,
  input  logic  dbrk_clr,
  input  logic  mask_we,
  input  byte_t mask_d,
  output byte_t isr,
  output logic  irq
);
  byte_t mask_q;
  logic  dbrk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      dbrk_q <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_d;
      if (brk_evt)       dbrk_q <= 1'b1;
      else if (dbrk_clr) dbrk_q <= 1'b0;
    end
  end

  always_comb begin
    isr          = '0;
    isr[IS_TX]   = tx_rdy;
    isr[IS_RX]   = rx_src_full ? rx_full : rx_rdy;
    isr[IS_DBRK] = dbrk_q;
  end

  assign irq = |(isr & mask_q);

  // R11
  brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> isr[IS_DBRK]);

  // R11
  brk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbrk_clr && !brk_evt) |=> !isr[IS_DBRK]);
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              rx_en,
  input  logic [BYTE_W-1:0] rxb_data,
  input  logic              rxb_nonempty,
  input  logic              rxb_full,
  input  logic [ERR_W-1:0]  rxb_err,
  output logic              rxb_pop,
  output logic              rxb_clear,
  output logic              rxb_err_clr,
  input  logic              brk_evt,
  output logic              irq
);
  localparam int PTR_W = $clog2(NUM_MODE);

  byte_t            mode_q [NUM_MODE];
  byte_t            baud_q [NUM_BAUD];
  logic [PTR_W-1:0] ptr_q;
  logic             tx_en_q, rx_en_q;
  logic             tx_en_d, rx_en_d;
  logic             ptr_rst, rx_rst, tx_rst, err_clr, dbrk_clr;
  logic             tx_empty;
  byte_t            status, isr;

  logic wr_mode, wr_cmd, wr_data, wr_int;
  assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
  assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign wr_int  = bus_wr && (bus_addr == OFS_INT);

  uart_cmd_decode u_cmd (
    .cmd_we   (wr_cmd),
    .cmd      (bus_wdata[6:0]),
    .tx_en_q  (tx_en_q),
    .rx_en_q  (rx_en_q),
    .tx_en_d  (tx_en_d),
    .rx_en_d  (rx_en_d),
    .ptr_rst  (ptr_rst),
    .rx_rst   (rx_rst),
    .tx_rst   (tx_rst),
    .err_clr  (err_clr),
    .dbrk_clr (dbrk_clr)
  );

  // the command byte's top bit carries no meaning
  logic unused_b7;
  assign unused_b7 = bus_wdata[7] & 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      tx_en_q <= tx_en_d;
      rx_en_q <= rx_en_d;
      if (ptr_rst)      ptr_q <= '0;
      else if (wr_mode) ptr_q <= PTR_W'(NUM_MODE - 1);
    end
  end

  for (genvar g = 0; g < NUM_MODE; g++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mode_q[g] <= '0;
      else if (wr_mode && ptr_q == PTR_W'(g)) mode_q[g] <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NUM_BAUD; g++) begin : g_baud
    localparam ofs_t BOFS = OFS_BAUD0 + ofs_t'(4 * g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            baud_q[g] <= '0;
      else if (bus_wr && bus_addr == BOFS)   baud_q[g] <= bus_wdata;
    end
  end

  uart_tx_hold u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_data),
    .load_data (bus_wdata),
    .flush     (tx_rst),
    .tx_en     (tx_en_q),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .empty     (tx_empty)
  );

  always_comb begin
    status                           = '0;
    status[ST_RXRDY]                 = rxb_nonempty;
    status[ST_FULL]                  = rxb_full;
    status[ST_TXRDY]                 = tx_en_q;
    status[ST_TXEMP]                 = tx_empty;
    status[ST_ERR0 +: ERR_W]         = rxb_err;
  end

  uart_irq_gen u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_rdy      (status[ST_TXRDY]),
    .rx_rdy      (status[ST_RXRDY]),
    .rx_full     (status[ST_FULL]),
    .rx_src_full (mode_q[0][MODE_RXSRC]),
    .brk_evt     (brk_evt),
    .dbrk_clr    (dbrk_clr),
    .mask_we     (wr_int),
    .mask_d      (bus_wdata),
    .isr         (isr),
    .irq         (irq)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_MODE:  bus_rdata = mode_q[ptr_q];
      OFS_STAT:  bus_rdata = status;
      OFS_DATA:  bus_rdata = rxb_nonempty ? rxb_data : '0;
      OFS_INT:   bus_rdata = isr;
      OFS_BAUD0: bus_rdata = baud_q[0];
      OFS_BAUD1: bus_rdata = baud_q[NUM_BAUD-1];
      default:   bus_rdata = '0;
    endcase
  end

  assign rxb_pop     = bus_rd && (bus_addr == OFS_DATA) && rxb_nonempty;
  assign rxb_clear   = rx_rst;
  assign rxb_err_clr = err_clr;
  assign rx_en       = rx_en_q;

  // R2
  ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (ptr_q == PTR_W'(NUM_MODE - 1)));

  // R12
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_pop |-> (bus_rdata == rxb_data));

  // R6
  tx_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && bus_wdata[3:2] == 2'd1) |=> status[ST_TXRDY]);
endmodule

// File: tb/test_uart_regfront.sv
`timescale 1ns/1ps
module test_uart_regfront;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] tx_data;
  logic       tx_valid, tx_ready = 1'b0;
  logic       rx_en;
  logic [7:0] rxb_data = '0;
  logic       rxb_nonempty = 1'b0, rxb_full = 1'b0;
  logic [3:0] rxb_err = '0;
  logic       rxb_pop, rxb_clear, rxb_err_clr;
  logic       brk_evt = 1'b0;
  logic       irq;

  int total = 0, bad = 0;
  logic [7:0] txlog [16];
  int         ntx = 0;
  logic       seen_clear, seen_errclr;

  always #2.5 clk = ~clk;

  uart_regfront i_uart_regfront (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_en(rx_en), .rxb_data(rxb_data), .rxb_nonempty(rxb_nonempty),
    .rxb_full(rxb_full), .rxb_err(rxb_err), .rxb_pop(rxb_pop), .rxb_clear(rxb_clear),
    .rxb_err_clr(rxb_err_clr), .brk_evt(brk_evt), .irq(irq)
  );

  always @(posedge clk)
    if (rst_n && tx_valid && tx_ready && ntx < 16) begin
      txlog[ntx] = tx_data;
      ntx = ntx + 1;
    end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1;
    seen_clear = rxb_clear;
    seen_errclr = rxb_err_clr;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 6'h3F;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d, output logic p);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata; p = rxb_pop;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 6'h3F;
  endtask

  task automatic rdchk(input string req, input logic [5:0] a, input logic [7:0] e);
    logic [7:0] d; logic p;
    rd(a, d, p);
    chk(req, d, e);
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rx_en", rx_en, 0);
    rdchk("R1 status", 6'h04, 8'h08);
    rdchk("R1 isr", 6'h14, 8'h00);
    rdchk("R1 mode", 6'h00, 8'h00);
  endtask

  task automatic t_mode();
    wr(6'h00, 8'h11);
    wr(6'h00, 8'h22);
    rdchk("R2 mode2 read", 6'h00, 8'h22);
    wr(6'h00, 8'h33);
    rdchk("R2 pointer sticks", 6'h00, 8'h33);
    wr(6'h08, 8'h10);
    rdchk("R2 pointer reset", 6'h00, 8'h11);
    wr(6'h00, 8'h00);
  endtask

  task automatic t_rx_read();
    logic [7:0] d; logic p;
    rxb_nonempty = 1; rxb_full = 1; rxb_err = 4'b1010; rxb_data = 8'h5A;
    rdchk("R3 status", 6'h04, 8'hAB);
    rd(6'h0C, d, p);
    chk("R12 data", d, 8'h5A);
    chk("R12 pop", p, 1);
    rxb_nonempty = 0; rxb_full = 0; rxb_err = 0;
    rd(6'h0C, d, p);
    chk("R12 empty data", d, 0);
    chk("R12 empty no pop", p, 0);
  endtask

  task automatic t_tx_hold();
    int n0 = ntx;
    wr(6'h0C, 8'h33);
    rdchk("R4 empty cleared", 6'h04, 8'h00);
    chk("R4 held no valid", tx_valid, 0);
    wr(6'h08, 8'h04);
    rdchk("R6 enabled", 6'h04, 8'h04);
    chk("R4 valid after enable", tx_valid, 1);
    repeat (3) @(negedge clk);
    chk("R5 stall keeps data", tx_data, 8'h33);
    chk("R5 stall no accept", ntx, n0);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    chk("R5 one accept", ntx, n0 + 1);
    chk("R5 byte", txlog[n0], 8'h33);
    rdchk("R5 empty set", 6'h04, 8'h0C);
    wr(6'h08, 8'h0C);
    rdchk("R6 reserved ignored", 6'h04, 8'h0C);
    wr(6'h08, 8'h08);
    rdchk("R6 disabled", 6'h04, 8'h08);
  endtask

  task automatic t_collide();
    int n0 = ntx;
    wr(6'h08, 8'h04);
    wr(6'h0C, 8'h41);
    tx_ready = 1;
    wr(6'h0C, 8'h42);
    @(negedge clk);
    tx_ready = 0;
    chk("R5 collide count", ntx, n0 + 2);
    chk("R5 collide first", txlog[n0], 8'h41);
    chk("R5 collide second", txlog[n0+1], 8'h42);
    rdchk("R5 collide empty", 6'h04, 8'h0C);
  endtask

  task automatic t_tx_reset();
    int n0 = ntx;
    wr(6'h0C, 8'h77);
    chk("R9 pre valid", tx_valid, 1);
    wr(6'h08, 8'h30);
    chk("R9 valid dropped", tx_valid, 0);
    rdchk("R9 status", 6'h04, 8'h08);
    wr(6'h08, 8'h04);
    chk("R9 byte discarded", tx_valid, 0);
    chk("R9 nothing sent", ntx, n0);
    wr(6'h08, 8'h08);
  endtask

  task automatic t_order();
    wr(6'h08, 8'h35);
    rdchk("R8 tx enabled after reset", 6'h04, 8'h0C);
    chk("R8 rx enabled", rx_en, 1);
    wr(6'h08, 8'h21);
    chk("R8 rx reset then enable", rx_en, 1);
    chk("R7 clear pulse", seen_clear, 1);
    wr(6'h08, 8'h02);
    chk("R7 rx off", rx_en, 0);
    wr(6'h08, 8'h01);
    wr(6'h08, 8'h03);
    chk("R7 reserved keeps", rx_en, 1);
    wr(6'h08, 8'h20);
    chk("R7 reset disables", rx_en, 0);
    chk("R7 reset clears", seen_clear, 1);
    wr(6'h08, 8'h08);
  endtask

  task automatic t_irq();
    wr(6'h08, 8'h04);
    rdchk("R10 isr tx", 6'h14, 8'h01);
    chk("R10 masked", irq, 0);
    wr(6'h14, 8'h01);
    chk("R10 tx irq", irq, 1);
    wr(6'h14, 8'h02);
    chk("R10 rx idle", irq, 0);
    rxb_nonempty = 1; #1;
    chk("R10 rx ready irq", irq, 1);
    rdchk("R10 isr both", 6'h14, 8'h03);
    wr(6'h08, 8'h10); wr(6'h00, 8'h40);
    rdchk("R10 full source", 6'h14, 8'h01);
    chk("R10 no irq", irq, 0);
    rxb_full = 1; #1;
    chk("R10 full irq", irq, 1);
    rxb_full = 0; rxb_nonempty = 0;
    wr(6'h08, 8'h10); wr(6'h00, 8'h00);
    wr(6'h08, 8'h08); wr(6'h14, 8'h00);
  endtask

  task automatic t_break();
    brk_evt = 1; @(negedge clk); brk_evt = 0;
    rdchk("R11 set", 6'h14, 8'h04);
    wr(6'h14, 8'h04);
    chk("R11 irq", irq, 1);
    wr(6'h08, 8'h50);
    rdchk("R11 cleared", 6'h14, 8'h00);
    brk_evt = 1;
    wr(6'h08, 8'h50);
    brk_evt = 0;
    rdchk("R11 event wins", 6'h14, 8'h04);
    wr(6'h08, 8'h50);
    wr(6'h14, 8'h00);
  endtask

  task automatic t_misc();
    wr(6'h04, 8'hFF);
    rdchk("R13 status write ignored", 6'h04, 8'h08);
    wr(6'h10, 8'hFF);
    rdchk("R13 unmapped read", 6'h10, 8'h00);
    rdchk("R13 cmd read", 6'h08, 8'h00);
    rdchk("R13 odd offset", 6'h02, 8'h00);
    wr(6'h08, 8'h40);
    chk("R13 err clear pulse", seen_errclr, 1);
    wr(6'h08, 8'h60); wr(6'h08, 8'h70);
    rdchk("R13 break cmds inert", 6'h04, 8'h08);
    rdchk("R13 isr untouched", 6'h14, 8'h00);
  endtask

  task automatic t_baud();
    wr(6'h18, 8'hA5);
    wr(6'h1C, 8'h3C);
    rdchk("R14 baud0", 6'h18, 8'hA5);
    rdchk("R14 baud1", 6'h1C, 8'h3C);
  endtask

  logic done = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_rx_read();
    t_tx_hold();
    t_collide();
    t_tx_reset();
    t_order();
    t_irq();
    t_break();
    t_misc();
    t_baud();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule